// File: doc/BRIEF.md
# Load-Use Interlock and Halt Controller

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it inspects the instruction word waiting in the IF/ID register and the word already in the ID/EX register. When the ID/EX word is a load whose destination register is read by the decode-stage instruction, the loaded value cannot reach execute in time. The block then freezes the program counter and IF/ID for one cycle and steers a no-operation word into ID/EX in place of the dependent instruction. Once that bubble has advanced, the load is no longer directly ahead, so the hold ends after a single cycle.

The same block watches the MEM/WB instruction word and declares the machine stopped when a HALT arrives there. A HALT seen earlier in the pipe may sit on a wrongly predicted path, and stores ahead of it still need to finish. Waiting until MEM/WB covers both cases. A branch squash raised by the execute stage overrides the interlock, because the instruction that would be held is about to be discarded.

Instruction fields: opcode in bits 31:26, first register field in bits 25:21, second register field in bits 20:16.

Top module: `lu_hazard_ctl`

## Requirements
- R1: When ID/EX holds a load (opcode 0x23) whose destination (bits 20:16) is nonzero and equals a register the IF/ID instruction reads, and `squash` is low, `hold` and `bubble` are both 1 in that cycle.
- R2: While `bubble` is 1, `idex_next` equals 0x00000020. When neither `bubble` nor `squash` is 1, `idex_next` equals `ifid_instr`.
- R3: A store (opcode 0x2B) in IF/ID reads both its base (bits 25:21) and its data register (bits 20:16), so a match on either field against the load destination raises the hold.
- R4: An R-type instruction (opcode 0x00) reads both bits 25:21 and 20:16. An add-immediate (0x08), a load (0x23) or a branch-if-zero (0x04) reads only bits 25:21, so a match on bits 20:16 alone does not hold. A HALT word (0xFC000000) reads no register.
- R5: A load whose destination is register 0 never raises `hold`.
- R6: An instruction other than a load in ID/EX never raises `hold`, even when it writes a register that IF/ID reads.
- R7: When `squash` is 1, `hold` and `bubble` are 0 and `idex_next` equals 0x00000020.
- R8: `halted` is 1 in the same cycle that the MEM/WB word has opcode 0x3F. It stays 1 in every later cycle until reset.
- R9: A HALT in IF/ID or ID/EX, with no HALT in MEM/WB, leaves `halted` at 0.
- R10: While `rst_n` is low and MEM/WB holds no HALT, `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ifid_instr | input | 32 | Instruction word in the IF/ID register |
| idex_instr | input | 32 | Instruction word in the ID/EX register |
| memwb_instr | input | 32 | Instruction word in the MEM/WB register |
| squash | input | 1 | Branch misprediction flush from the execute stage |
| hold | output | 1 | Freeze the PC and IF/ID this cycle |
| bubble | output | 1 | Load a no-operation word into ID/EX this cycle |
| idex_next | output | 32 | Word the ID/EX register captures at the next edge |
| halted | output | 1 | Machine stopped; sticky until reset |

## Verification
The interlock is tried with a load ahead of R-type, store, add-immediate, load and branch consumers. The dependency is placed first in one register field and then in the other. This separates the consumers that read both fields from those that read only one. Control cases cover a load to register 0, a non-load producer writing the same register, and a dependency that coincides with a squash. Together they show that the hold follows the opcode of the producer and the squash priority, not just equal register numbers. For halting, HALT words are placed first in the early stages and then in MEM/WB, and are removed afterwards. This shows that only the MEM/WB stage triggers the stop, and that the stop persists once triggered.

// File: rtl/lu_hazard_pkg.sv
// Shared opcode constants for the load-use interlock and halt controller.
// Assumes a 6-bit opcode at the top of each instruction word.
package lu_hazard_pkg;
    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_BEQZ  = 6'h04;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_HALT  = 6'h3F;
endpackage

// File: rtl/lu_src_decode.sv
// Works out which register fields the decode-stage instruction reads.
// Assumes the opcode and the two register fields arrive already sliced.
// Unknown opcodes read nothing.
module lu_src_decode
    import lu_hazard_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int OPC_W  = 6
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [REG_AW-1:0] field_a,
    input  logic [REG_AW-1:0] field_b,
    output logic [1:0]        use_src,
    output logic [REG_AW-1:0] src_a,
    output logic [REG_AW-1:0] src_b
);
    // Classify the opcode into the set of register fields it reads.
    always_comb begin
        case (opc)
            OPC_ALU, OPC_STORE:           use_src = 2'b11;
            OPC_LOAD, OPC_ADDI, OPC_BEQZ: use_src = 2'b01;
            default:                      use_src = 2'b00;
        endcase
    end

    assign src_a = field_a;
    assign src_b = field_b;
endmodule

// File: rtl/lu_load_detect.sv
// Reports whether the ID/EX instruction is a load that writes a real register.
// A load to register 0 is treated as producing nothing.
module lu_load_detect
    import lu_hazard_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int OPC_W  = 6
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [REG_AW-1:0] dest_field,
    output logic              load_live,
    output logic [REG_AW-1:0] load_reg
);
    // A load counts only when its destination is not the zero register.
    always_comb begin
        load_live = (opc == OPC_LOAD) && (dest_field != '0);
        load_reg  = dest_field;
    end
endmodule

// File: rtl/lu_halt_track.sv
// Raises the stop flag when HALT sits in MEM/WB and keeps it until reset.
// Assumes a synchronous active-low reset.
module lu_halt_track
    import lu_hazard_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] memwb_opc,
    output logic             halted
);
    logic hit;
    logic seen_q;

    assign hit = (memwb_opc == OPC_HALT);

    // Remember that a HALT has reached MEM/WB.
    always_ff @(posedge clk) begin
        if (!rst_n)   seen_q <= 1'b0;
        else if (hit) seen_q <= 1'b1;
    end

    assign halted = hit | seen_q;
endmodule

// File: rtl/lu_hazard_ctl.sv
// Top of the decode-stage load-use interlock and halt controller.
// Compares the load destination in ID/EX with the sources of IF/ID.
// Gives squash priority over the hold, and reports a stop once HALT reaches MEM/WB.
module lu_hazard_ctl #(
    parameter int          INSTR_W  = 32,
    parameter int          REG_AW   = 5,
    parameter int          OPC_W    = 6,
    parameter logic [31:0] NOP_WORD = 32'h0000_0020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic [INSTR_W-1:0] idex_instr,
    input  logic [INSTR_W-1:0] memwb_instr,
    input  logic               squash,
    output logic               hold,
    output logic               bubble,
    output logic [INSTR_W-1:0] idex_next,
    output logic               halted
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_AW;
    localparam int RB_LSB  = RA_LSB - REG_AW;
    localparam int NSRC    = 2;

    logic [1:0]        use_src;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] src_v [NSRC];
    logic [NSRC-1:0]   src_hit;
    logic              load_live;
    logic [REG_AW-1:0] load_reg;
    logic              dep;
    logic              unused_bits;

    assign unused_bits = ^{idex_instr[RA_LSB-1:0] ^ idex_instr[RA_LSB-1:0],
                           idex_instr[RB_LSB-1:0], memwb_instr[OPC_LSB-1:0]};

    lu_src_decode #(.REG_AW(REG_AW), .OPC_W(OPC_W)) u_src (
        .opc     (ifid_instr[INSTR_W-1:OPC_LSB]),
        .field_a (ifid_instr[OPC_LSB-1:RA_LSB]),
        .field_b (ifid_instr[RA_LSB-1:RB_LSB]),
        .use_src (use_src),
        .src_a   (src_a),
        .src_b   (src_b)
    );

    lu_load_detect #(.REG_AW(REG_AW), .OPC_W(OPC_W)) u_load (
        .opc        (idex_instr[INSTR_W-1:OPC_LSB]),
        .dest_field (idex_instr[RA_LSB-1:RB_LSB]),
        .load_live  (load_live),
        .load_reg   (load_reg)
    );

    lu_halt_track #(.OPC_W(OPC_W)) u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .memwb_opc (memwb_instr[INSTR_W-1:OPC_LSB]),
        .halted    (halted)
    );

    assign src_v[0] = src_a;
    assign src_v[1] = src_b;

    // One comparator per source field against the load destination.
    for (genvar p = 0; p < NSRC; p++) begin : g_cmp
        assign src_hit[p] = use_src[p] && (src_v[p] == load_reg);
    end

    // Combine the comparisons; a squash cancels the hold.
    always_comb begin
        dep    = load_live && (|src_hit);
        hold   = dep && !squash;
        bubble = hold;
    end

    // Select the word ID/EX captures next.
    always_comb begin
        if (squash || bubble) idex_next = NOP_WORD[INSTR_W-1:0];
        else                  idex_next = ifid_instr;
    end
endmodule

// File: rtl/lu_hazard_chk.sv
// Property checker bound to the load-use interlock and halt controller.
module lu_hazard_chk
    import lu_hazard_pkg::*;
#(
    parameter int          INSTR_W  = 32,
    parameter int          OPC_W    = 6,
    parameter int          REG_AW   = 5,
    parameter logic [31:0] NOP_WORD = 32'h0000_0020
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] ifid_instr,
    input logic [INSTR_W-1:0] idex_instr,
    input logic [INSTR_W-1:0] memwb_instr,
    input logic               squash,
    input logic               hold,
    input logic               bubble,
    input logic [INSTR_W-1:0] idex_next,
    input logic               halted
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_AW;
    localparam int RB_LSB  = RA_LSB - REG_AW;

    logic [OPC_W-1:0]  if_op, ex_op, wb_op;
    logic [REG_AW-1:0] if_a, ex_b;
    logic              unused_chk;

    assign if_op = ifid_instr[INSTR_W-1:OPC_LSB];
    assign if_a  = ifid_instr[OPC_LSB-1:RA_LSB];
    assign ex_op = idex_instr[INSTR_W-1:OPC_LSB];
    assign ex_b  = idex_instr[RA_LSB-1:RB_LSB];
    assign wb_op = memwb_instr[INSTR_W-1:OPC_LSB];
    assign unused_chk = ^{ifid_instr[RA_LSB-1:0], idex_instr[OPC_LSB-1:RA_LSB],
                          idex_instr[RB_LSB-1:0], memwb_instr[OPC_LSB-1:0]};

    AST_BUBBLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (idex_next == NOP_WORD[INSTR_W-1:0]));                  // R2
    AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!hold && !bubble && idex_next == NOP_WORD[INSTR_W-1:0])); // R7
    AST_ZERO_DEST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_op == OPC_LOAD && ex_b == '0) |-> !hold);                      // R5
    AST_NONLOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_op != OPC_LOAD) |-> !hold);                                    // R6
    AST_ONE_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((if_op == OPC_ADDI || if_op == OPC_BEQZ) && if_a != ex_b) |-> !hold); // R4
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);                                                // R8
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (wb_op == OPC_HALT));                            // R9
endmodule

bind lu_hazard_ctl lu_hazard_chk #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .REG_AW  (REG_AW),
    .NOP_WORD(NOP_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ifid_instr  (ifid_instr),
    .idex_instr  (idex_instr),
    .memwb_instr (memwb_instr),
    .squash      (squash),
    .hold        (hold),
    .bubble      (bubble),
    .idex_next   (idex_next),
    .halted      (halted)
);

// File: tb/lu_hazard_ctl_tb.sv
// Directed bench for the load-use interlock and halt controller.
module lu_hazard_ctl_tb;
    localparam logic [31:0] NOP  = 32'h0000_0020;
    localparam logic [31:0] HALT = 32'hFC00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ifid_instr = NOP;
    logic [31:0] idex_instr = NOP;
    logic [31:0] memwb_instr = NOP;
    logic        squash = 1'b0;
    logic        hold, bubble, halted;
    logic [31:0] idex_next;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lu_hazard_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .idex_instr(idex_instr),
        .memwb_instr(memwb_instr), .squash(squash), .hold(hold), .bubble(bubble),
        .idex_next(idex_next), .halted(halted)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {6'h00, rs, rt, rd, 11'h020};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt);
        return {op, rs, rt, 16'h0004};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a new set of words just after an edge, then settle to the falling edge.
    task automatic apply(logic [31:0] fi, logic [31:0] ex, logic [31:0] wb, logic sq);
        @(posedge clk); #1;
        ifid_instr = fi; idex_instr = ex; memwb_instr = wb; squash = sq;
        @(negedge clk);
    endtask

    task automatic expect_hold(string req, logic exp_hold);
        check({req, " hold"}, {31'd0, hold}, {31'd0, exp_hold});
        check({req, " bubble"}, {31'd0, bubble}, {31'd0, exp_hold});
        check({req, " idex_next"}, idex_next, exp_hold ? NOP : ifid_instr);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 halted in reset", {31'd0, halted}, 32'd0);
        check("R10 hold in reset", {31'd0, hold}, 32'd0);
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    task automatic t_rtype();
        logic [31:0] ld = enc_i(6'h23, 5'd1, 5'd5);
        apply(enc_r(5'd5, 5'd2, 5'd3), ld, NOP, 1'b0);
        expect_hold("R1 rtype field a", 1'b1);
        apply(enc_r(5'd2, 5'd5, 5'd3), ld, NOP, 1'b0);
        expect_hold("R4 rtype field b", 1'b1);
        apply(enc_r(5'd1, 5'd2, 5'd5), ld, NOP, 1'b0);
        expect_hold("R2 no dependence passes word", 1'b0);
    endtask

    task automatic t_store();
        logic [31:0] ld = enc_i(6'h23, 5'd1, 5'd7);
        apply(enc_i(6'h2B, 5'd1, 5'd7), ld, NOP, 1'b0);
        expect_hold("R3 store data reg", 1'b1);
        apply(enc_i(6'h2B, 5'd7, 5'd2), ld, NOP, 1'b0);
        expect_hold("R3 store base reg", 1'b1);
    endtask

    task automatic t_one_field();
        logic [31:0] ld = enc_i(6'h23, 5'd1, 5'd9);
        apply(enc_i(6'h08, 5'd1, 5'd9), ld, NOP, 1'b0);
        expect_hold("R4 addi field b only", 1'b0);
        apply(enc_i(6'h08, 5'd9, 5'd1), ld, NOP, 1'b0);
        expect_hold("R4 addi field a", 1'b1);
        apply(enc_i(6'h23, 5'd2, 5'd9), ld, NOP, 1'b0);
        expect_hold("R4 load field b only", 1'b0);
        apply(enc_i(6'h04, 5'd9, 5'd0), ld, NOP, 1'b0);
        expect_hold("R4 beqz field a", 1'b1);
        apply(enc_i(6'h04, 5'd0, 5'd9), ld, NOP, 1'b0);
        expect_hold("R4 beqz field b only", 1'b0);
        apply(HALT | {6'h0, 5'd9, 5'd9, 16'h0}, ld, NOP, 1'b0);
        expect_hold("R4 halt reads nothing", 1'b0);
    endtask

    task automatic t_zero_dest();
        apply(enc_r(5'd0, 5'd0, 5'd4), enc_i(6'h23, 5'd3, 5'd0), NOP, 1'b0);
        expect_hold("R5 load to r0", 1'b0);
    endtask

    task automatic t_nonload();
        apply(enc_r(5'd6, 5'd2, 5'd3), enc_i(6'h08, 5'd1, 5'd6), NOP, 1'b0);
        expect_hold("R6 addi producer", 1'b0);
        apply(enc_r(5'd6, 5'd6, 5'd3), enc_r(5'd1, 5'd2, 5'd6), NOP, 1'b0);
        expect_hold("R6 rtype producer", 1'b0);
    endtask

    task automatic t_squash();
        apply(enc_r(5'd5, 5'd5, 5'd3), enc_i(6'h23, 5'd1, 5'd5), NOP, 1'b1);
        check("R7 hold under squash", {31'd0, hold}, 32'd0);
        check("R7 bubble under squash", {31'd0, bubble}, 32'd0);
        check("R7 next word under squash", idex_next, NOP);
    endtask

    task automatic t_halt();
        apply(HALT, NOP, NOP, 1'b0);
        check("R9 halt in ifid", {31'd0, halted}, 32'd0);
        apply(NOP, HALT, NOP, 1'b0);
        check("R9 halt in idex", {31'd0, halted}, 32'd0);
        apply(NOP, NOP, HALT, 1'b0);
        check("R8 halt in memwb", {31'd0, halted}, 32'd1);
        apply(NOP, NOP, NOP, 1'b0);
        check("R8 halted sticky", {31'd0, halted}, 32'd1);
        apply(NOP, NOP, NOP, 1'b0);
        check("R8 halted still sticky", {31'd0, halted}, 32'd1);
        t_reset();
        @(negedge clk);
        check("R10 halted cleared by reset", {31'd0, halted}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_rtype();
        t_store();
        t_one_field();
        t_zero_dest();
        t_nonload();
        t_squash();
        t_halt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule